// File: doc/BRIEF.md
# Segmented Binary Divider Chain

This block is a 24-stage binary divider. It counts falling edges of a slow count input and keeps the count in a chain of divide-by-two stages. The whole chain can therefore count up to 2^24 = 16,777,216 pulses before it wraps. Stage n toggles at the count-input rate divided by 2^n. Only the top seven stages (stages 18 to 24) are driven out as divided outputs.

The chain runs synchronously on a system clock. A registered copy of the count input is used to detect its falling edge, and each detected edge advances the chain by exactly one. A clear input zeroes every stage and takes priority over counting.

A segmented test select cuts the chain into three 8-stage sections. Each section then takes every count pulse directly, so 255 pulses fill all 24 stages with ones. After that, one pulse in normal mode carries the whole chain from all ones to all zeros in a single step. The full chain state is also driven out on a debug port.

Top module: `div_chain_top`

## Requirements
- R1: While `clear` is high at a clock edge, every stage reads zero from the next cycle on. This holds even if a falling edge of `cnt_in` happens at the same time.
- R2: The chain advances only on a falling edge of `cnt_in` (a 1 followed by a 0 in consecutive clock samples). The new value is visible on `dbg_state` two clock edges after `cnt_in` is first sampled low. A rising edge never counts.
- R3: With `seg_test` low, `dbg_state` behaves as one 24-bit binary counter. It increments by one per falling edge, carries across bit 7→8 and bit 15→16, and wraps from 0xFFFFFF to 0x000000.
- R4: `tap_q[k]` equals stage 18+k, which is `dbg_state[17+k]`, for k = 0 to 6. So `tap_q[6]` is the most significant stage.
- R5: With `seg_test` high, `dbg_state[7:0]`, `dbg_state[15:8]` and `dbg_state[23:16]` each increment by one per falling edge. Each field wraps modulo 256 on its own, and no carry passes between fields.
- R6: Starting from all zeros, 255 falling edges in segmented mode leave `dbg_state` at 0xFFFFFF.
- R7: Returning `seg_test` to low keeps the stage contents unchanged. One further falling edge then takes 0xFFFFFF to 0x000000.
- R8: A change on `seg_test` with no falling edge on `cnt_in` leaves the state unchanged.
- R9: A steady `cnt_in`, whether held high or held low, produces no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clear | input | 1 | Synchronous active-high clear of all stages |
| cnt_in | input | 1 | Count input; falling edges advance the chain |
| seg_test | input | 1 | 1 = three parallel 8-stage sections, 0 = one 24-stage chain |
| tap_q | output | 7 | Stages 18..24 (bit 0 = stage 18) |
| dbg_state | output | 24 | Full chain state, bit 0 = stage 1 |

## Verification
The upper stages and the full-chain rollover cannot be reached from the ports in normal mode within any practical run, because that takes millions of pulses. The stimulus therefore uses segmented mode to preload the three sections: 255 pulses give all ones, and 0x5A pulses give the pattern 0x5A5A5A. It then switches back to normal mode. There, single pulses check the all-ones rollover and the tap outputs, and a run of 256 pulses carries a low section of zero across both section boundaries to wrap the whole chain.

// File: rtl/div_chain_pkg.sv
package div_chain_pkg;
  localparam int DC_SEC_W   = 8;
  localparam int DC_NUM_SEC = 3;
  localparam int DC_TAP_W   = 7;
endpackage

// File: rtl/div_chain_edge.sv
// Falling-edge detector for the slow count input.
module div_chain_edge (
  input  logic clk,
  input  logic clear,
  input  logic din,
  output logic fall
);
  logic smp_now, smp_old;

  always_ff @(posedge clk) begin
    if (clear) begin
      smp_now <= 1'b0;
      smp_old <= 1'b0;
    end else begin
      smp_now <= din;
      smp_old <= smp_now;
    end
  end

  assign fall = smp_old & ~smp_now;
endmodule

// File: rtl/div_chain_sec.sv
// One section of binary stages with an increment enable.
module div_chain_sec #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clear,
  input  logic         inc,
  output logic [W-1:0] q,
  output logic         full
);
  always_ff @(posedge clk) begin
    if (clear)    q <= '0;
    else if (inc) q <= q + W'(1);
  end

  assign full = &q;
endmodule

// File: rtl/div_chain_top.sv
module div_chain_top
  import div_chain_pkg::*;
#(
  parameter int SEC_W   = DC_SEC_W,
  parameter int NUM_SEC = DC_NUM_SEC,
  parameter int TAP_W   = DC_TAP_W
) (
  input  logic                     clk,
  input  logic                     clear,
  input  logic                     cnt_in,
  input  logic                     seg_test,
  output logic [TAP_W-1:0]         tap_q,
  output logic [SEC_W*NUM_SEC-1:0] dbg_state
);
  localparam int STAGES = SEC_W * NUM_SEC;

  logic               mode_q;
  logic               fall;
  logic [NUM_SEC-1:0] sec_inc;
  logic [NUM_SEC-1:0] sec_full;
  logic [STAGES-1:0]  stage_q;

  // Mode is registered so a change lands on a clean clock boundary.
  always_ff @(posedge clk) begin
    if (clear) mode_q <= 1'b0;
    else       mode_q <= seg_test;
  end

  div_chain_edge u_edge (
    .clk  (clk),
    .clear(clear),
    .din  (cnt_in),
    .fall (fall)
  );

  for (genvar g = 0; g < NUM_SEC; g++) begin : g_sec
    if (g == 0) begin : g_first
      assign sec_inc[g] = fall;
    end else begin : g_next
      // Segmented: every section sees the pulse. Series: carry from below.
      assign sec_inc[g] = mode_q ? fall : (sec_inc[g-1] & sec_full[g-1]);
    end

    div_chain_sec #(.W(SEC_W)) u_sec (
      .clk  (clk),
      .clear(clear),
      .inc  (sec_inc[g]),
      .q    (stage_q[g*SEC_W +: SEC_W]),
      .full (sec_full[g])
    );
  end

  assign dbg_state = stage_q;
  assign tap_q     = stage_q[STAGES-1 -: TAP_W];
endmodule

// File: rtl/div_chain_chk.sv
module div_chain_chk #(
  parameter int SEC_W   = 8,
  parameter int NUM_SEC = 3
) (
  input logic                     clk,
  input logic                     clear,
  input logic                     fall,
  input logic                     mode_q,
  input logic [SEC_W*NUM_SEC-1:0] state
);
  localparam int STAGES = SEC_W * NUM_SEC;

  p_clear_zero_r1: assert property (@(posedge clk)
    clear |=> (state == '0));

  p_single_edge_r2: assert property (@(posedge clk) disable iff (clear)
    fall |=> !fall);

  p_hold_r9: assert property (@(posedge clk) disable iff (clear)
    !fall |=> $stable(state));

  p_series_step_r3: assert property (@(posedge clk) disable iff (clear)
    (fall && !mode_q) |=> (state == $past(state) + STAGES'(1)));

  for (genvar i = 0; i < NUM_SEC; i++) begin : g_chk
    p_sec_step_r5: assert property (@(posedge clk) disable iff (clear)
      (fall && mode_q) |=>
        (state[i*SEC_W +: SEC_W] == $past(state[i*SEC_W +: SEC_W]) + SEC_W'(1)));
  end
endmodule

bind div_chain_top div_chain_chk #(.SEC_W(SEC_W), .NUM_SEC(NUM_SEC)) u_chk (
  .clk   (clk),
  .clear (clear),
  .fall  (fall),
  .mode_q(mode_q),
  .state (stage_q)
);

// File: tb/div_chain_top_tb_top.sv
module div_chain_top_tb_top;
  typedef struct {
    logic [23:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        clear = 1'b1;
  logic        cnt_in = 1'b0;
  logic        seg_test = 1'b0;
  logic [6:0]  tap_q;
  logic [23:0] dbg_state;

  int    n_checks = 0;
  int    n_fails  = 0;
  bit    done     = 1'b0;
  item_t sb_q[$];
  logic [23:0] ref_st = '0;
  bit    ref_mode = 1'b0;

  always #4 clk = ~clk;

  div_chain_top dut_i (
    .clk      (clk),
    .clear    (clear),
    .cnt_in   (cnt_in),
    .seg_test (seg_test),
    .tap_q    (tap_q),
    .dbg_state(dbg_state)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_now(input string tag);
    item_t it;
    it.exp = ref_st;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic pulse(input string tag);
    cnt_in = 1'b1;
    tick(3);
    cnt_in = 1'b0;
    tick(3);
    if (ref_mode) begin
      for (int s = 0; s < 3; s++) ref_st[s*8 +: 8] = ref_st[s*8 +: 8] + 8'd1;
    end else begin
      ref_st = ref_st + 24'd1;
    end
    expect_now(tag);
  endtask

  task automatic set_mode(input bit m, input string tag);
    seg_test = m;
    ref_mode = m;
    tick(3);
    expect_now(tag);
  endtask

  // Monitor: pops expected items and compares away from the active edge.
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_checks++;
        if (dbg_state !== it.exp) begin
          n_fails++;
          $display("FAIL %s: dbg_state=%h expected %h", it.tag, dbg_state, it.exp);
        end
        n_checks++;
        if (tap_q !== it.exp[23:17]) begin
          n_fails++;
          $display("FAIL R4 (%s): tap_q=%h expected %h", it.tag, tap_q, it.exp[23:17]);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    tick(4);
    clear = 1'b0;
    ref_st = '0;
    expect_now("R1 reset state");
    tick(2);

    for (int k = 0; k < 5; k++) pulse("R2/R3 series count");

    // R9: hold high, then hold low, with no falling edge between checks
    cnt_in = 1'b1;
    tick(20);
    expect_now("R9 steady high, rising edge not counted");
    tick(2);
    cnt_in = 1'b0;
    tick(20);
    ref_st = ref_st + 24'd1;  // the single release edge counts once
    expect_now("R9 steady low after one fall");
    tick(2);

    // R8: mode toggles alone
    set_mode(1'b1, "R8 enter segmented, no change");
    set_mode(1'b0, "R8 leave segmented, no change");

    // R1: clear overrides a simultaneous falling edge
    cnt_in = 1'b1;
    tick(3);
    cnt_in = 1'b0;
    clear  = 1'b1;
    tick(4);
    clear  = 1'b0;
    ref_st = '0;
    expect_now("R1 clear beats count");
    tick(2);

    // R5/R6: fill all stages in segmented mode
    set_mode(1'b1, "R8 mode entry at zero");
    for (int k = 0; k < 255; k++) pulse("R5/R6 segmented fill");
    expect_now("R6 all ones after 255");
    tick(2);

    // R7: release keeps contents, one pulse rolls over
    set_mode(1'b0, "R7 release keeps all ones");
    pulse("R7 single pulse rollover");

    // R4: preload a pattern and read the taps
    set_mode(1'b1, "R8 mode entry");
    for (int k = 0; k < 8'h5A; k++) pulse("R4/R5 preload pattern");
    set_mode(1'b0, "R4 pattern 5A5A5A held");
    pulse("R3 series step from pattern");

    // R5: independent wrap, no carry between sections
    set_mode(1'b1, "R8 mode entry");
    for (int k = 0; k < 8'hA5; k++) pulse("R5 independent section wrap");

    // R3: series carries across both section boundaries and wraps
    set_mode(1'b0, "R7 release keeps FFFF00");
    for (int k = 0; k < 256; k++) pulse("R3 series carry and wrap");

    tick(6);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule